// File: doc/BRIEF.md
# Integer Shift Execution Unit

This unit carries out the shift operations of a 32-bit integer datapath: shifting left, logical shifting right and arithmetic shifting right. The amount comes either from a second register operand or from the instruction's 12-bit immediate field. Operand values, the immediate, the function fields and a register-or-immediate select are presented together. One clock edge later the unit returns the shifted value and a flag marking an immediate encoding that is not valid.

A single shared log-depth shifter does all three operations. It is built for right shifts only, and a left shift runs through it with its operand and result bit-reversed. Vacated bits are filled with zero, or with the operand's top bit for arithmetic right shifts. A parameter removes the output register when the surrounding pipeline wants the result in the same cycle.

Top module: `shift_unit`

## Requirements
- R1: With funct3 = 001 the result is the operand shifted toward the MSB, with the vacated low bits set to zero (42 shifted by 2 gives 168).
- R2: A logical right shift sets the vacated high bits to zero (0xFFFFFFD6 shifted by 2 gives 0x3FFFFFF5).
- R3: An arithmetic right shift fills the vacated high bits with the operand's bit 31 (0xFFFFFFD6 shifted by 2 gives 0xFFFFFFF5).
- R4: In register form the amount is src_b[4:0], and src_b[31:5] has no effect, so an amount of 32 returns the operand unchanged.
- R5: In register form, funct3 = 101 selects a right shift, with funct7[5] = 1 making it arithmetic and funct7[5] = 0 making it logical.
- R6: In immediate form (use_imm = 1) the amount is imm[4:0], and for funct3 = 101 imm[10] = 1 selects arithmetic.
- R7: In immediate form, illegal is raised and the result is zero when imm[11:5] is not 0000000 for a left shift, or is neither 0000000 nor 0100000 for a right shift. This includes every amount above 31.
- R8: In register form illegal is never raised, and funct7 bits other than bit 5 have no effect.
- R9: For any funct3 other than 001 and 101 the result is zero and illegal stays low.
- R10: An amount of zero passes the operand through unchanged for all three shift kinds.
- R11: With the output register enabled (the default), outputs appear one clock after the inputs, and both outputs are zero while rst_n is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Active-low synchronous reset |
| src_a | input | 32 | Operand to be shifted |
| src_b | input | 32 | Second register operand, whose low bits give the amount |
| imm | input | 12 | Immediate field: amount in the low bits, type bits above |
| funct3 | input | 3 | Operation select |
| funct7 | input | 7 | Register-form type bits |
| use_imm | input | 1 | 1 selects immediate form, 0 selects register form |
| result | output | 32 | Shifted value |
| illegal | output | 1 | Malformed immediate shift encoding |

## Verification
On every cycle, the assertions check the zero low bits of left shifts and the top-bit fill of each right-shift kind. They also check zero-amount passthrough, the flag and the zeroed result for immediate amounts above 31, the absence of the flag in register form, and the zero result for other funct3 values. Exact shifted values are checked only by the bench. It compares every clock against a behavioural model using the language's shift operators, across directed encodings and random operands. Masking of the upper amount bits, the exact-value examples and the reset state are also shown only by the bench.

// File: rtl/shu_pkg.sv
package shu_pkg;

    typedef enum logic [1:0] {
        SH_NONE   = 2'd0,
        SH_LEFT   = 2'd1,
        SH_RLOG   = 2'd2,
        SH_RARITH = 2'd3
    } shu_op_e;

    localparam logic [2:0] F3_LEFT  = 3'b001;
    localparam logic [2:0] F3_RIGHT = 3'b101;

    // bit of funct7 / imm that selects arithmetic fill
    localparam int F7_ARITH_BIT  = 5;
    localparam int IMM_ARITH_BIT = 10;

endpackage

// File: rtl/shu_decode.sv
module shu_decode
    import shu_pkg::*;
#(
    parameter int IMM_W   = 12,
    parameter int SHAMT_W = 5
) (
    input  logic [2:0]         funct3,
    input  logic               f7_arith,
    input  logic [IMM_W-1:0]   imm,
    input  logic               use_imm,
    input  logic [SHAMT_W-1:0] reg_amt,
    output shu_op_e            op,
    output logic [SHAMT_W-1:0] amt,
    output logic               bad
);

    localparam int TYPE_W = IMM_W - SHAMT_W;
    localparam logic [TYPE_W-1:0] ARITH_MASK = TYPE_W'(1) << (IMM_ARITH_BIT - SHAMT_W);

    logic [TYPE_W-1:0] type_bits;
    logic              arith_sel;

    always_comb begin
        type_bits = imm[IMM_W-1:SHAMT_W];
        amt       = use_imm ? imm[SHAMT_W-1:0] : reg_amt;
        arith_sel = use_imm ? imm[IMM_ARITH_BIT] : f7_arith;
        op        = SH_NONE;
        bad       = 1'b0;
        unique case (funct3)
            F3_LEFT: begin
                op  = SH_LEFT;
                bad = use_imm && (type_bits != '0);
            end
            F3_RIGHT: begin
                op  = arith_sel ? SH_RARITH : SH_RLOG;
                bad = use_imm && ((type_bits & ~ARITH_MASK) != '0);
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/shu_barrel.sv
module shu_barrel #(
    parameter int WIDTH   = 32,
    parameter int SHAMT_W = 5
) (
    input  logic [WIDTH-1:0]   din,
    input  logic [SHAMT_W-1:0] amt,
    input  logic               to_left,
    input  logic               arith,
    output logic [WIDTH-1:0]   dout
);

    logic [WIDTH-1:0] stage [SHAMT_W+1];
    logic [WIDTH-1:0] tail;
    logic             fill;

    always_comb begin
        fill = arith & ~to_left & din[WIDTH-1];
        for (int i = 0; i < WIDTH; i++) begin
            stage[0][i] = to_left ? din[WIDTH-1-i] : din[i];
        end
    end

    for (genvar s = 0; s < SHAMT_W; s++) begin : g_stage
        localparam int STEP = 1 << s;
        assign stage[s+1] = amt[s] ? {{STEP{fill}}, stage[s][WIDTH-1:STEP]} : stage[s];
    end

    assign tail = stage[SHAMT_W];

    always_comb begin
        for (int i = 0; i < WIDTH; i++) begin
            dout[i] = to_left ? tail[WIDTH-1-i] : tail[i];
        end
    end

endmodule

// File: rtl/shift_unit.sv
module shift_unit
    import shu_pkg::*;
#(
    parameter int XLEN    = 32,
    parameter int IMM_W   = 12,
    parameter bit REG_OUT = 1'b1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [XLEN-1:0] src_a,
    input  logic [XLEN-1:0] src_b,
    input  logic [IMM_W-1:0] imm,
    input  logic [2:0]      funct3,
    input  logic [6:0]      funct7,
    input  logic            use_imm,
    output logic [XLEN-1:0] result,
    output logic            illegal
);

    localparam int SHAMT_W = $clog2(XLEN);

    typedef struct packed {
        logic [XLEN-1:0] res;
        logic            bad;
    } out_t;

    shu_op_e            dec_op;
    logic [SHAMT_W-1:0] dec_amt;
    logic               dec_bad;
    logic [XLEN-1:0]    shifted;
    out_t               out_d, out_q;
    logic               unused_hi;

    assign unused_hi = ^{src_b[XLEN-1:SHAMT_W], funct7[6], funct7[4:0]};

    shu_decode #(.IMM_W(IMM_W), .SHAMT_W(SHAMT_W)) u_decode (
        .funct3   (funct3),
        .f7_arith (funct7[F7_ARITH_BIT]),
        .imm      (imm),
        .use_imm  (use_imm),
        .reg_amt  (src_b[SHAMT_W-1:0]),
        .op       (dec_op),
        .amt      (dec_amt),
        .bad      (dec_bad)
    );

    shu_barrel #(.WIDTH(XLEN), .SHAMT_W(SHAMT_W)) u_barrel (
        .din     (src_a),
        .amt     (dec_amt),
        .to_left (dec_op == SH_LEFT),
        .arith   (dec_op == SH_RARITH),
        .dout    (shifted)
    );

    always_comb begin
        out_d.bad = dec_bad;
        out_d.res = (dec_op == SH_NONE || dec_bad) ? '0 : shifted;
    end

    if (REG_OUT) begin : g_reg
        always_ff @(posedge clk) begin
            if (!rst_n) out_q <= '0;
            else        out_q <= out_d;
        end

        p_left_low_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
            (dec_op == SH_LEFT && !dec_bad)
            |=> ((out_q.res & ~({XLEN{1'b1}} << $past(dec_amt))) == '0));

        p_logic_top_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (dec_op == SH_RLOG && !dec_bad && dec_amt != '0)
            |=> !out_q.res[XLEN-1]);

        p_arith_top_sign_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (dec_op == SH_RARITH && !dec_bad)
            |=> (out_q.res[XLEN-1] == $past(src_a[XLEN-1])));

        p_imm_range_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (use_imm && dec_op != SH_NONE && imm[SHAMT_W])
            |=> (out_q.bad && out_q.res == '0));

        p_reg_never_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
            !use_imm |=> !out_q.bad);

        p_other_funct_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (dec_op == SH_NONE) |=> (out_q == '0));

        p_zero_amount_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (dec_op != SH_NONE && !dec_bad && dec_amt == '0)
            |=> (out_q.res == $past(src_a)));
    end else begin : g_comb
        assign out_q = out_d;
    end

    assign result  = out_q.res;
    assign illegal = out_q.bad;

endmodule

// File: tb/shift_unit_bench.sv
module shift_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src_a = '0;
    logic [31:0] src_b = '0;
    logic [11:0] imm = '0;
    logic [2:0]  funct3 = '0;
    logic [6:0]  funct7 = '0;
    logic        use_imm = 1'b0;
    logic [31:0] result;
    logic        illegal;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    shift_unit u_shift_unit (
        .clk(clk), .rst_n(rst_n), .src_a(src_a), .src_b(src_b), .imm(imm),
        .funct3(funct3), .funct7(funct7), .use_imm(use_imm),
        .result(result), .illegal(illegal)
    );

    function automatic logic [32:0] model(logic [31:0] a, logic [31:0] b, logic [11:0] im,
                                          logic [2:0] f3, logic [6:0] f7, logic ui);
        int unsigned n;
        logic [6:0]  upper;
        logic        ar;
        n     = ui ? int'(im[4:0]) : int'(b[4:0]);
        upper = im[11:5];
        if (f3 == 3'b001) begin
            if (ui && upper != 7'h00) return {32'h0, 1'b1};
            return {a << n, 1'b0};
        end
        if (f3 == 3'b101) begin
            if (ui && upper != 7'h00 && upper != 7'h20) return {32'h0, 1'b1};
            ar = ui ? im[10] : f7[5];
            if (ar) return {32'($signed(a) >>> n), 1'b0};
            return {a >> n, 1'b0};
        end
        return {32'h0, 1'b0};
    endfunction

    task automatic step(logic [31:0] a, logic [31:0] b, logic [11:0] im,
                        logic [2:0] f3, logic [6:0] f7, logic ui, string tag);
        logic [32:0] exp;
        src_a = a; src_b = b; imm = im; funct3 = f3; funct7 = f7; use_imm = ui;
        exp = model(a, b, im, f3, f7, ui);
        @(posedge clk);
        @(negedge clk);
        checks++;
        if (result !== exp[32:1] || illegal !== exp[0]) begin
            errors++;
            $display("FAIL %s: result=%h illegal=%b expected result=%h illegal=%b",
                     tag, result, illegal, exp[32:1], exp[0]);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R11: outputs held at zero under reset, even with live inputs
        src_a = 32'hDEADBEEF; src_b = 32'h3; funct3 = 3'b001; use_imm = 1'b0;
        repeat (3) @(negedge clk);
        checks++;
        if (result !== 32'h0 || illegal !== 1'b0) begin
            errors++;
            $display("FAIL R11: result=%h illegal=%b expected result=0 illegal=0", result, illegal);
        end
        rst_n = 1'b1;

        // R1 / R6: left shift in both forms
        step(32'd42, 32'd2, 12'h000, 3'b001, 7'h00, 1'b0, "R1");
        step(32'd42, 32'd0, 12'h002, 3'b001, 7'h00, 1'b1, "R6");
        step(32'h8000_0001, 32'd31, 12'h000, 3'b001, 7'h00, 1'b0, "R1");
        // R2 / R3 / R6: right shifts from the immediate
        step(32'hFFFF_FFD6, 32'd0, 12'h002, 3'b101, 7'h00, 1'b1, "R2");
        step(32'hFFFF_FFD6, 32'd0, 12'h402, 3'b101, 7'h00, 1'b1, "R3");
        step(32'd42, 32'd0, 12'h402, 3'b101, 7'h00, 1'b1, "R6");
        // R5: register-form right shifts
        step(32'hFFFF_FFD6, 32'd2, 12'h000, 3'b101, 7'h20, 1'b0, "R5");
        step(32'hFFFF_FFD6, 32'd2, 12'h000, 3'b101, 7'h00, 1'b0, "R5");
        step(32'h8000_0000, 32'd31, 12'h000, 3'b101, 7'h20, 1'b0, "R3");
        // R4: upper amount bits ignored
        step(32'h1234_5678, 32'd32, 12'h000, 3'b001, 7'h00, 1'b0, "R4");
        step(32'h1234_5678, 32'hFFFF_FFE1, 12'h000, 3'b001, 7'h00, 1'b0, "R4");
        step(32'hF000_0000, 32'h0000_0044, 12'h000, 3'b101, 7'h20, 1'b0, "R4");
        // R10: zero amount in every kind
        step(32'hA5A5_5A5A, 32'd0, 12'h000, 3'b001, 7'h00, 1'b0, "R10");
        step(32'hA5A5_5A5A, 32'd0, 12'h000, 3'b101, 7'h00, 1'b0, "R10");
        step(32'hA5A5_5A5A, 32'd0, 12'h400, 3'b101, 7'h00, 1'b1, "R10");
        // R7: malformed immediates
        step(32'hFFFF_FFFF, 32'd0, 12'h022, 3'b001, 7'h00, 1'b1, "R7");
        step(32'hFFFF_FFFF, 32'd0, 12'h402, 3'b001, 7'h00, 1'b1, "R7");
        step(32'hFFFF_FFFF, 32'd0, 12'h802, 3'b101, 7'h00, 1'b1, "R7");
        step(32'hFFFF_FFFF, 32'd0, 12'h43F, 3'b101, 7'h00, 1'b1, "R7");
        // R8: register form ignores other funct7 bits and never flags
        step(32'h0000_00FF, 32'd4, 12'hFFF, 3'b001, 7'h7F, 1'b0, "R8");
        step(32'h8000_00FF, 32'd4, 12'hFFF, 3'b101, 7'h5F, 1'b0, "R8");
        // R9: other funct3 values
        step(32'hFFFF_FFFF, 32'd3, 12'h003, 3'b000, 7'h00, 1'b0, "R9");
        step(32'hFFFF_FFFF, 32'd3, 12'hFFF, 3'b111, 7'h20, 1'b1, "R9");

        // random sweep, compared every clock
        for (int i = 0; i < 400; i++) begin
            logic [2:0] f3;
            logic [11:0] im;
            f3 = ($urandom % 3 == 0) ? 3'($urandom) : (($urandom % 2) ? 3'b001 : 3'b101);
            im = ($urandom % 4 == 0) ? 12'($urandom) : {1'b0, 1'($urandom), 5'b0, 5'($urandom)};
            step($urandom, $urandom, im, f3, 7'($urandom), 1'($urandom), "R5");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule